// File: doc/BRIEF.md
# Incremental Converter Timing and Decimator

This block runs the conversion sequence of one column's second-order incremental sigma-delta converter, and it decimates the converter's one-bit stream into an 11-bit word. A start pulse makes a small generator raise an internal enable for a number of converter clocks set by the bit-depth code. The enable length is the only setting that sets the resolution.

The sequencer samples that enable on the converter clock. On the first sampled-high cycle it resets the modulator and clears two cascaded accumulators. While enable stays high it issues an integrate strobe and a compare strobe each cycle and adds the modulator bit into the accumulators. When enable falls it shifts the second accumulator, clamps it to 11 bits, loads it into the result register and pulses a valid flag. The converter ends early when a halt request drops enable. If fewer than two bits were accumulated, the conversion is dropped with no result.

Top module: `incr_adc_ctrl`

## Requirements
- R1: A start pulse accepted while idle yields exactly 8, 16, 32, 40 or 64 integrate strobes for depth codes 0, 1, 2, 3 and 4 (4, 6, 8, 9 and 10 bits; enable lengths 10, 18, 34, 42 and 66 clocks).
- R2: Depth codes 5, 6 and 7 behave exactly like code 3 (9 bits, the default).
- R3: `mod_rst` pulses for exactly one cycle at the start of each conversion. It comes before the first integrate strobe and is never high together with `ph_int`.
- R4: `ph_cmp` is high exactly in the cycle after each cycle in which `ph_int` is high.
- R5: With A1 the running count of 1-bits taken on integrate strobes and A2 the running sum of A1 after each update, the result is min(2047, A2 >> S). S is 0 for code 4 and 1 for every other code.
- R6: `result_valid` is a one-cycle pulse. `result` changes only in a cycle where `result_valid` is high.
- R7: If fewer than two integrate strobes occurred when enable falls, no valid pulse is given and `result` keeps its previous value.
- R8: `halt` ends enable at once. A conversion with `halt` sampled on the h-th clock after the start was accepted yields h-2 integrate strobes and, when that is two or more, a result computed by R5.
- R9: A start pulse while a conversion is in progress is ignored and does not lengthen it.
- R10: After reset, `mod_rst`, `ph_int`, `ph_cmp` and `result_valid` are low and `result` is 0.
- R11: The depth code is captured when start is accepted. Changing `depth_sel` during a conversion does not change its length or its scaling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| depth_sel | input | 3 | Bit-depth code |
| start | input | 1 | Request one conversion |
| halt | input | 1 | Drop enable early |
| mod_bit | input | 1 | Modulator output bit |
| mod_rst | output | 1 | Modulator reset strobe |
| ph_int | output | 1 | Integrate phase strobe; the bit is taken at the next edge |
| ph_cmp | output | 1 | Compare phase strobe |
| result | output | 11 | Decimated, clamped result |
| result_valid | output | 1 | One-cycle pulse when `result` loads |

## Verification
The bit stream is tried as all zeros, all ones and evenly spread densities of 1/3, 3/8, 2/5, 1/2 and 5/7. All-zero and all-one streams pin down the ends of the range and the per-depth shift. An all-one stream at 10 bits is the only case that reaches the clamp. The fractional densities separate a correct second-order weighting, in which early bits count more, from a plain count of ones or a swapped accumulator order. Early halts at 1, 3, 4 and 20 clocks bracket the two-bit abort threshold. A mid-conversion restart with a changed depth code shows whether the length and shift were captured when the start was accepted.

// File: rtl/incr_adc_pkg.sv
package incr_adc_pkg;

    localparam int DEPTH_W = 3;
    localparam int CNT_W   = 7;
    localparam int ACC1_W  = 7;
    localparam int ACC2_W  = 12;
    localparam int RES_W   = 11;
    localparam logic [ACC2_W-1:0] RES_MAX = ACC2_W'((1 << RES_W) - 1);

    typedef struct packed {
        logic               en;
        logic [CNT_W-1:0]   left;
        logic [DEPTH_W-1:0] code;
    } gen_t;

    typedef struct packed {
        logic               en_s;
        logic               active;
        logic               modrst;
        logic               ph_int;
        logic               ph_cmp;
        logic               sh;
        logic [CNT_W-1:0]   cnt;
        logic [ACC1_W-1:0]  acc1;
        logic [ACC2_W-1:0]  acc2;
        logic [RES_W-1:0]   result;
        logic               valid;
    } seq_t;

    // enable length in converter clocks per depth code
    function automatic logic [CNT_W-1:0] enable_len(input logic [DEPTH_W-1:0] c);
        case (c)
            3'd0:    return CNT_W'(10);
            3'd1:    return CNT_W'(18);
            3'd2:    return CNT_W'(34);
            3'd4:    return CNT_W'(66);
            default: return CNT_W'(42);
        endcase
    endfunction

    // output right shift per depth code
    function automatic logic scale_shift(input logic [DEPTH_W-1:0] c);
        return (c == 3'd4) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/incr_adc_engen.sv
module incr_adc_engen
    import incr_adc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               halt_i,
    input  logic [DEPTH_W-1:0] depth_i,
    output logic               en_o,
    output logic [DEPTH_W-1:0] code_o
);

    gen_t q, d;

    always_comb begin
        d = q;
        if (q.en) begin
            if (halt_i || q.left == '0) begin
                d.en = 1'b0;
            end else begin
                d.left = q.left - 1'b1;
            end
        end else if (start_i && !halt_i) begin
            d.en   = 1'b1;
            d.left = enable_len(depth_i) - 1'b1;
            d.code = depth_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{en: 1'b0, left: '0, code: 3'd3};
        end else begin
            q <= d;
        end
    end

    assign en_o   = q.en;
    assign code_o = q.code;

    AST_START_RAISES_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.en && start_i && !halt_i) |=> q.en); // R1
    AST_HALT_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> !q.en); // R8

endmodule

// File: rtl/incr_adc_seq.sv
module incr_adc_seq
    import incr_adc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [DEPTH_W-1:0] code_i,
    input  logic               bit_i,
    output logic               mod_rst_o,
    output logic               ph_int_o,
    output logic               ph_cmp_o,
    output logic [RES_W-1:0]   result_o,
    output logic               valid_o
);

    seq_t q, d;
    logic [ACC2_W-1:0] scaled;

    always_comb begin
        scaled   = q.acc2 >> q.sh;
        d        = q;
        d.en_s   = en_i;
        d.modrst = 1'b0;
        d.valid  = 1'b0;
        d.ph_cmp = q.ph_int;
        if (q.ph_int) begin
            d.acc1 = q.acc1 + {{(ACC1_W-1){1'b0}}, bit_i};
            d.acc2 = q.acc2 + ACC2_W'(d.acc1);
            d.cnt  = q.cnt + 1'b1;
        end
        if (q.en_s && !q.active) begin
            // first sampled-high cycle: reset modulator, clear decimator
            d.active = 1'b1;
            d.modrst = 1'b1;
            d.acc1   = '0;
            d.acc2   = '0;
            d.cnt    = '0;
            d.sh     = scale_shift(code_i);
        end else if (!q.en_s && q.active) begin
            // enable fell: load result unless too short
            d.active = 1'b0;
            if (q.cnt >= CNT_W'(2)) begin
                d.result = (scaled > RES_MAX) ? RES_MAX[RES_W-1:0] : scaled[RES_W-1:0];
                d.valid  = 1'b1;
            end
        end
        d.ph_int = d.active && d.en_s && !d.modrst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mod_rst_o = q.modrst;
    assign ph_int_o  = q.ph_int;
    assign ph_cmp_o  = q.ph_cmp;
    assign result_o  = q.result;
    assign valid_o   = q.valid;

    AST_CMP_AFTER_INT: assert property (@(posedge clk) disable iff (!rst_n)
        q.ph_int |=> q.ph_cmp); // R4
    AST_INT_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ph_int) |-> $past(q.modrst)); // R3
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !q.valid |-> $stable(q.result)); // R6
    AST_NO_SHORT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.valid) |-> ($past(q.cnt) >= CNT_W'(2))); // R7

endmodule

// File: rtl/incr_adc_ctrl.sv
module incr_adc_ctrl
    import incr_adc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        depth_sel,
    input  logic              start,
    input  logic              halt,
    input  logic              mod_bit,
    output logic              mod_rst,
    output logic              ph_int,
    output logic              ph_cmp,
    output logic [10:0]       result,
    output logic              result_valid
);

    logic               en_w;
    logic [DEPTH_W-1:0] code_w;

    incr_adc_engen u_engen (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .halt_i  (halt),
        .depth_i (depth_sel),
        .en_o    (en_w),
        .code_o  (code_w)
    );

    incr_adc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_w),
        .code_i    (code_w),
        .bit_i     (mod_bit),
        .mod_rst_o (mod_rst),
        .ph_int_o  (ph_int),
        .ph_cmp_o  (ph_cmp),
        .result_o  (result),
        .valid_o   (result_valid)
    );

endmodule

// File: tb/incr_adc_ctrl_tb.sv
module incr_adc_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  depth_sel = 3'd0;
    logic        start = 1'b0;
    logic        halt = 1'b0;
    logic        mod_bit = 1'b0;
    logic        mod_rst, ph_int, ph_cmp, result_valid;
    logic [10:0] result;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // per-run observations
    int g_k, g_a2, g_valid, g_res, g_rst, g_perr, g_dbl;

    // {depth, p, q, expected strobes}
    localparam logic [17:0] VEC [9] = '{
        {3'd0, 4'd0, 4'd1, 7'd8},
        {3'd0, 4'd1, 4'd1, 7'd8},
        {3'd1, 4'd1, 4'd2, 7'd16},
        {3'd2, 4'd3, 4'd8, 7'd32},
        {3'd3, 4'd5, 4'd7, 7'd40},
        {3'd4, 4'd1, 4'd1, 7'd64},
        {3'd4, 4'd1, 4'd3, 7'd64},
        {3'd7, 4'd1, 4'd2, 7'd40},
        {3'd5, 4'd2, 4'd5, 7'd40}
    };

    incr_adc_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .depth_sel    (depth_sel),
        .start        (start),
        .halt         (halt),
        .mod_bit      (mod_bit),
        .mod_rst      (mod_rst),
        .ph_int       (ph_int),
        .ph_cmp       (ph_cmp),
        .result       (result),
        .result_valid (result_valid)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_res(input int depth, input int a2);
        int v;
        v = (depth == 4) ? a2 : (a2 >> 1);
        return (v > 2047) ? 2047 : v;
    endfunction

    // evenly spread density p/q
    function automatic logic pat_bit(input int k, input int p, input int q);
        return (((k + 1) * p) / q - (k * p) / q) != 0;
    endfunction

    task automatic run_conv(input int depth, input int p, input int q,
                            input int halt_at, input int disturb_at);
        int a1;
        logic prev_ph;
        logic b;
        g_k = 0; g_a2 = 0; g_valid = 0; g_res = -1; g_rst = 0; g_perr = 0; g_dbl = 0;
        a1 = 0;
        @(negedge clk);
        depth_sel = depth[2:0];
        start = 1'b1;
        prev_ph = ph_int;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            start = 1'b0;
            halt  = 1'b0;
            if (i == halt_at - 1) halt = 1'b1;
            if (i == disturb_at) begin
                start = 1'b1;
                depth_sel = 3'd0;
            end
            if (ph_cmp !== prev_ph) g_perr++;
            if (mod_rst) begin
                g_rst++;
                if (g_k != 0) g_perr++;
            end
            if (mod_rst && ph_int) g_perr++;
            if (g_valid != 0) begin
                if (result_valid) g_dbl++;
                break;
            end
            if (result_valid) begin
                g_valid = 1;
                g_res = int'(result);
            end
            b = pat_bit(g_k, p, q);
            mod_bit = b;
            if (ph_int) begin
                a1 = a1 + int'(b);
                g_a2 = g_a2 + a1;
                g_k++;
            end
            prev_ph = ph_int;
        end
        start = 1'b0;
        halt = 1'b0;
    endtask

    initial begin
        int last_res;
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(!mod_rst && !ph_int && !ph_cmp && !result_valid, "R10 strobes in reset",
            int'({mod_rst, ph_int, ph_cmp, result_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(result == 11'd0 && !result_valid, "R10 result after reset", int'(result), 0);

        // vector table: R1, R2, R3, R4, R5, R6
        foreach (VEC[vi]) begin
            int dep, pp, qq, nn, er;
            dep = int'(VEC[vi][17:15]);
            pp  = int'(VEC[vi][14:11]);
            qq  = int'(VEC[vi][10:7]);
            nn  = int'(VEC[vi][6:0]);
            run_conv(dep, pp, qq, 0, -1);
            chk(g_k == nn, (dep > 4) ? "R2 strobe count" : "R1 strobe count", g_k, nn);
            er = exp_res(dep, g_a2);
            chk(g_valid == 1 && g_res == er, "R5 result", g_res, er);
            chk(g_dbl == 0, "R6 valid one cycle", g_dbl, 0);
            chk(g_rst == 1, "R3 modulator reset pulses", g_rst, 1);
            chk(g_perr == 0, "R3 R4 strobe ordering", g_perr, 0);
        end
        last_res = int'(result);
        chk(last_res == exp_res(5, g_a2), "R6 result held", last_res, exp_res(5, g_a2));

        // R7/R8: halt after 3 clocks -> 1 strobe, aborted
        run_conv(3, 1, 1, 3, -1);
        chk(g_k == 1, "R8 strobes with halt at 3", g_k, 1);
        chk(g_valid == 0, "R7 no valid on abort", g_valid, 0);
        chk(int'(result) == last_res, "R7 result kept on abort", int'(result), last_res);
        chk(g_rst == 1, "R3 reset on aborted run", g_rst, 1);

        // R7: halt after 1 clock -> no strobes
        run_conv(0, 1, 1, 1, -1);
        chk(g_k == 0 && g_valid == 0, "R7 halt at 1", g_valid, 0);
        chk(int'(result) == last_res, "R7 result kept halt at 1", int'(result), last_res);

        // R7/R8 boundary: halt after 4 clocks -> 2 strobes, valid
        run_conv(3, 1, 1, 4, -1);
        chk(g_k == 2, "R8 strobes with halt at 4", g_k, 2);
        chk(g_valid == 1 && g_res == 1, "R7 two-strobe result", g_res, 1);

        // R8: halt after 20 clocks at 10 bits, all ones
        run_conv(4, 1, 1, 20, -1);
        chk(g_k == 18, "R8 strobes with halt at 20", g_k, 18);
        chk(g_valid == 1 && g_res == exp_res(4, g_a2), "R8 early result", g_res, exp_res(4, g_a2));

        // R9/R11: restart and depth change mid-conversion
        run_conv(3, 1, 2, 0, 10);
        chk(g_k == 40, "R9 R11 length kept", g_k, 40);
        chk(g_valid == 1 && g_res == exp_res(3, g_a2), "R11 shift kept", g_res, exp_res(3, g_a2));
        chk(g_rst == 1, "R9 no second reset", g_rst, 1);
        repeat (3) @(negedge clk);
        chk(!ph_int && !result_valid, "R9 no follow-on conversion", int'(ph_int), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule